// File: doc/BRIEF.md
# Load-Color Squash Tracker

This block follows which scheduler entries depend, directly or through any chain of producers, on loads whose cache outcome is still unknown. Each outstanding load owns one color, a bit position in a small vector, and every scheduler entry holds one such vector. When an instruction is dispatched, its vector is the OR of its producers' vectors, and a load also sets the bit of the color it is given. Because the OR carries inherited bits forward, a grandchild of a load has that load's bit without any search through the dependence graph.

When a load misses, its color is broadcast and the block reports a squash mask naming every entry whose vector holds that bit. Entries that do not depend on the load are left alone. Squashed instructions stay in the scheduler for replay. The block reports a hold mask naming every entry with a nonzero vector, and the scheduler must not release those entries. When a load is confirmed as a hit, its bit is cleared in every entry and its color goes back to the pool. If a load is dispatched while all colors are taken, the block stalls it.

Each color has its own three-state machine. The states are `C_FREE` (unowned), `C_INFLIGHT` (owned by a load that has not resolved) and `C_REPLAY` (owned by a load that missed and is being replayed). The transitions are:
- `T_ALLOC`: from `C_FREE` to `C_INFLIGHT` when a dispatched load is given the color.
- `T_MISS`: from `C_INFLIGHT` to `C_REPLAY` on a miss.
- `T_REMISS`: from `C_REPLAY` back to `C_REPLAY` on a further miss.
- `T_CONFIRM`: from `C_INFLIGHT` or `C_REPLAY` to `C_FREE` on a hit confirmation.

Top module: `load_color_tracker`

## Requirements
- R1: After reset, every entry vector is zero, `hold_mask` and `squash_mask` are zero, and `disp_color` is 0 with `disp_stall` low.
- R2: A non-load dispatch writes the OR of the vectors of its valid parents (`disp_par0_*`, `disp_par1_*`) into the target entry. The result is visible in `hold_mask` on the cycle after the dispatch edge.
- R3: A dispatched load is given the lowest-numbered free color, shown on `disp_color` in the same cycle, and its entry vector gets that color's bit in addition to the inherited bits. A color freed by a hit can be allocated from the next cycle.
- R4: A miss on an owned color C sets bit e of `squash_mask` on the cycle after the miss edge, for every entry e whose vector holds bit C. This includes indirect descendants. The mask lasts for one cycle.
- R5: An entry whose vector lacks bit C is not squashed by a miss on C.
- R6: Bit e of `hold_mask` is high exactly when entry e's vector is nonzero.
- R7: A hit confirmation on an owned color clears that bit in every entry vector and returns the color to the free pool.
- R8: If a load is dispatched while all 8 colors are owned, `disp_stall` goes high in that cycle and no entry is written. A non-load dispatch in the same situation proceeds.
- R9: A miss does not free the color or clear any vector bit, so a repeated miss on the same color squashes the same entries again.
- R10: A dispatch in the same cycle as a miss on a color it inherits is included in that miss's squash mask. A dispatch in the same cycle as a hit does not inherit the confirmed bit.
- R11: A miss or hit on a free color is ignored. If a hit and a miss name the same color in one cycle, the hit wins and nothing is squashed.
- R12: A dispatch into an entry replaces that entry's previous vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_entry | input | 4 | Entry being written |
| disp_is_load | input | 1 | Dispatched instruction is a load |
| disp_par0_valid | input | 1 | First parent present |
| disp_par0_entry | input | 4 | First parent entry |
| disp_par1_valid | input | 1 | Second parent present |
| disp_par1_entry | input | 4 | Second parent entry |
| disp_stall | output | 1 | Load dispatch refused, no free color |
| disp_color | output | 3 | Color given to a load dispatched this cycle |
| miss_valid | input | 1 | Load miss event |
| miss_color | input | 3 | Color of the missing load |
| hit_valid | input | 1 | Hit confirmation event |
| hit_color | input | 3 | Color of the confirmed load |
| squash_mask | output | 16 | Entries to squash, one cycle after a miss |
| hold_mask | output | 16 | Entries that must stay resident |

## Verification
Several events can arrive in the same cycle: a dispatch, a miss and a hit. They all act on the same vector state, so the order in which they are applied decides the outcome. The bench sends a dispatch whose parent carries color C together with a miss on C, and expects the new child in the squash mask. It sends a dispatch together with a hit on the inherited color, and expects the child to have an empty vector. It sends a hit and a miss on one color together, and expects an empty squash mask with the bit cleared. Each result is judged from `squash_mask` and `hold_mask` one cycle after the shared edge.

// File: rtl/lcst_pkg.sv
package lcst_pkg;

    typedef enum logic [1:0] {
        C_FREE     = 2'd0,
        C_INFLIGHT = 2'd1,
        C_REPLAY   = 2'd2
    } color_state_e;

endpackage

// File: rtl/lcst_color_fsm.sv
module lcst_color_fsm
    import lcst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alloc_i,
    input  logic miss_i,
    input  logic hit_i,
    output logic busy_o,
    output logic miss_act_o
);

    color_state_e state_q;
    color_state_e state_n;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            C_FREE: begin
                if (alloc_i) state_n = C_INFLIGHT;       // T_ALLOC
            end
            C_INFLIGHT: begin
                if (hit_i)       state_n = C_FREE;       // T_CONFIRM
                else if (miss_i) state_n = C_REPLAY;     // T_MISS
            end
            C_REPLAY: begin
                if (hit_i) state_n = C_FREE;             // T_CONFIRM
                else       state_n = C_REPLAY;           // T_REMISS or wait
            end
            default: state_n = C_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= C_FREE;
        else        state_q <= state_n;
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        miss_act_o = 1'b0;
        unique case (state_q)
            C_FREE: begin
                busy_o     = 1'b0;
                miss_act_o = 1'b0;
            end
            C_INFLIGHT, C_REPLAY: begin
                busy_o     = 1'b1;
                miss_act_o = miss_i && !hit_i;
            end
            default: begin
                busy_o     = 1'b0;
                miss_act_o = 1'b0;
            end
        endcase
    end

    p_hit_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && state_q != C_FREE) |=> state_q == C_FREE);

    p_miss_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_i && !hit_i && state_q != C_FREE) |=> state_q == C_REPLAY);

    p_free_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_FREE && !alloc_i) |=> state_q == C_FREE);

endmodule

// File: rtl/lcst_color_alloc.sv
module lcst_color_alloc #(
    parameter int NUM_COLORS = 8,
    localparam int CW = $clog2(NUM_COLORS)
) (
    input  logic [NUM_COLORS-1:0] busy_i,
    output logic                  any_free_o,
    output logic [CW-1:0]         idx_o
);

    always_comb begin
        any_free_o = 1'b0;
        idx_o      = '0;
        for (int i = NUM_COLORS - 1; i >= 0; i--) begin
            if (!busy_i[i]) begin
                any_free_o = 1'b1;
                idx_o      = CW'(i);
            end
        end
    end

endmodule

// File: rtl/lcst_vec_array.sv
module lcst_vec_array #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_COLORS  = 8,
    localparam int EW = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [EW-1:0]          wr_entry_i,
    input  logic                   par0_v_i,
    input  logic [EW-1:0]          par0_i,
    input  logic                   par1_v_i,
    input  logic [EW-1:0]          par1_i,
    input  logic [NUM_COLORS-1:0]  own_bits_i,
    input  logic [NUM_COLORS-1:0]  clear_bits_i,
    input  logic [NUM_COLORS-1:0]  squash_bits_i,
    output logic [NUM_ENTRIES-1:0] hold_mask_o,
    output logic [NUM_ENTRIES-1:0] squash_mask_o
);

    logic [NUM_COLORS-1:0] vec_q [NUM_ENTRIES];
    logic [NUM_COLORS-1:0] inherit;

    always_comb begin
        inherit = own_bits_i;
        if (par0_v_i) inherit = inherit | vec_q[par0_i];
        if (par1_v_i) inherit = inherit | vec_q[par1_i];
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic [NUM_COLORS-1:0] vec_n;
        logic                  sq_q;

        always_comb begin
            if (wr_en_i && wr_entry_i == EW'(e)) vec_n = inherit;
            else                                 vec_n = vec_q[e];
            vec_n = vec_n & ~clear_bits_i;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[e] <= '0;
                sq_q     <= 1'b0;
            end else begin
                vec_q[e] <= vec_n;
                sq_q     <= |(vec_n & squash_bits_i);
            end
        end

        assign hold_mask_o[e]   = |vec_q[e];
        assign squash_mask_o[e] = sq_q;
    end

    p_squash_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_mask_o & ~hold_mask_o) == '0);

    p_clear_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_bits_i != '0 && !wr_en_i && hold_mask_o == '0) |=> hold_mask_o == '0);

endmodule

// File: rtl/load_color_tracker.sv
module load_color_tracker #(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_COLORS  = 8,
    localparam int EW = $clog2(NUM_ENTRIES),
    localparam int CW = $clog2(NUM_COLORS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [EW-1:0]          disp_entry,
    input  logic                   disp_is_load,
    input  logic                   disp_par0_valid,
    input  logic [EW-1:0]          disp_par0_entry,
    input  logic                   disp_par1_valid,
    input  logic [EW-1:0]          disp_par1_entry,
    output logic                   disp_stall,
    output logic [CW-1:0]          disp_color,
    input  logic                   miss_valid,
    input  logic [CW-1:0]          miss_color,
    input  logic                   hit_valid,
    input  logic [CW-1:0]          hit_color,
    output logic [NUM_ENTRIES-1:0] squash_mask,
    output logic [NUM_ENTRIES-1:0] hold_mask
);

    logic [NUM_COLORS-1:0] busy;
    logic [NUM_COLORS-1:0] miss_act;
    logic [NUM_COLORS-1:0] clear_bits;
    logic [NUM_COLORS-1:0] own_bits;
    logic                  any_free;
    logic [CW-1:0]         alloc_idx;
    logic                  disp_fire;
    logic                  load_fire;

    lcst_color_alloc #(.NUM_COLORS(NUM_COLORS)) u_alloc (
        .busy_i     (busy),
        .any_free_o (any_free),
        .idx_o      (alloc_idx)
    );

    assign disp_stall = disp_valid && disp_is_load && !any_free;
    assign disp_fire  = disp_valid && !disp_stall;
    assign load_fire  = disp_fire && disp_is_load;
    assign disp_color = alloc_idx;

    for (genvar c = 0; c < NUM_COLORS; c++) begin : g_color
        lcst_color_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (load_fire && alloc_idx == CW'(c)),
            .miss_i     (miss_valid && miss_color == CW'(c)),
            .hit_i      (hit_valid && hit_color == CW'(c)),
            .busy_o     (busy[c]),
            .miss_act_o (miss_act[c])
        );
        assign clear_bits[c] = hit_valid && hit_color == CW'(c) && busy[c];
        assign own_bits[c]   = load_fire && alloc_idx == CW'(c);
    end

    lcst_vec_array #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .NUM_COLORS  (NUM_COLORS)
    ) u_vec (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (disp_fire),
        .wr_entry_i    (disp_entry),
        .par0_v_i      (disp_par0_valid),
        .par0_i        (disp_par0_entry),
        .par1_v_i      (disp_par1_valid),
        .par1_i        (disp_par1_entry),
        .own_bits_i    (own_bits),
        .clear_bits_i  (clear_bits),
        .squash_bits_i (miss_act),
        .hold_mask_o   (hold_mask),
        .squash_mask_o (squash_mask)
    );

    p_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stall |-> $countones(busy) == NUM_COLORS);

    p_alloc_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> busy[$past(alloc_idx)]);

    p_stall_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_stall && !hit_valid) |=> $stable(hold_mask) || $past(miss_valid));

    p_free_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !busy[miss_color]) |=> squash_mask == '0);

    p_squash_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> squash_mask == '0);

endmodule

// File: tb/test_load_color_tracker.sv
`timescale 1ns/1ps
module test_load_color_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [3:0]  disp_entry = '0;
    logic        disp_is_load = 1'b0;
    logic        disp_par0_valid = 1'b0;
    logic [3:0]  disp_par0_entry = '0;
    logic        disp_par1_valid = 1'b0;
    logic [3:0]  disp_par1_entry = '0;
    logic        disp_stall;
    logic [2:0]  disp_color;
    logic        miss_valid = 1'b0;
    logic [2:0]  miss_color = '0;
    logic        hit_valid = 1'b0;
    logic [2:0]  hit_color = '0;
    logic [15:0] squash_mask;
    logic [15:0] hold_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    load_color_tracker i_load_color_tracker (
        .clk             (clk),
        .rst_n           (rst_n),
        .disp_valid      (disp_valid),
        .disp_entry      (disp_entry),
        .disp_is_load    (disp_is_load),
        .disp_par0_valid (disp_par0_valid),
        .disp_par0_entry (disp_par0_entry),
        .disp_par1_valid (disp_par1_valid),
        .disp_par1_entry (disp_par1_entry),
        .disp_stall      (disp_stall),
        .disp_color      (disp_color),
        .miss_valid      (miss_valid),
        .miss_color      (miss_color),
        .hit_valid       (hit_valid),
        .hit_color       (hit_color),
        .squash_mask     (squash_mask),
        .hold_mask       (hold_mask)
    );

    typedef struct packed {
        logic        dv;
        logic [3:0]  de;
        logic        dl;
        logic        p0v;
        logic [3:0]  p0;
        logic        p1v;
        logic [3:0]  p1;
        logic        mv;
        logic [2:0]  mc;
        logic        hv;
        logic [2:0]  hc;
        logic        xs;
        logic [2:0]  xc;
        logic [15:0] xsq;
        logic [15:0] xh;
        logic [3:0]  rq;
    } stim_t;

    localparam int NSTEP = 14;
    localparam stim_t TBL [NSTEP] = '{
        // dv de  dl p0v p0 p1v p1 mv mc hv hc xs xc  xsq      xh       rq
        '{1, 0,  1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 16'h0001, 3},  // R3 load e0 gets color 0
        '{1, 1,  0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 16'h0003, 2},  // R2 child of e0
        '{1, 2,  1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 16'h0007, 3},  // R3 dependent load, color 1
        '{1, 3,  1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 16'h0000, 16'h000F, 3},  // R3 independent load, color 2
        '{1, 4,  0, 1, 2, 1, 3, 0, 0, 0, 0, 0, 0, 16'h0000, 16'h001F, 2},  // R2 two parents
        '{0, 0,  0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 16'h0017, 16'h001F, 5},  // R4 R5 miss c0, e3 spared
        '{0, 0,  0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 16'h0017, 16'h001F, 9},  // R9 repeat miss
        '{0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 16'h0000, 16'h001F, 7},  // R7 hit c1
        '{0, 0,  0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 16'h0000, 16'h001F, 11}, // R11 miss on free c1
        '{1, 5,  1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000, 16'h003F, 3},  // R3 freed c1 reused
        '{0, 0,  0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 16'h0000, 16'h0038, 7},  // R7 hit c0
        '{1, 6,  0, 1, 4, 0, 0, 1, 2, 0, 0, 0, 0, 16'h0058, 16'h0078, 10}, // R10 dispatch with miss
        '{1, 7,  0, 1, 6, 0, 0, 0, 0, 1, 2, 0, 0, 16'h0000, 16'h0020, 10}, // R10 dispatch with hit
        '{0, 0,  0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 16'h0000, 16'h0000, 11}  // R11 hit beats miss
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input stim_t s);
        string rs;
        rs = $sformatf("R%0d", s.rq);
        @(negedge clk);
        disp_valid = s.dv;  disp_entry = s.de;  disp_is_load = s.dl;
        disp_par0_valid = s.p0v; disp_par0_entry = s.p0;
        disp_par1_valid = s.p1v; disp_par1_entry = s.p1;
        miss_valid = s.mv; miss_color = s.mc;
        hit_valid = s.hv;  hit_color = s.hc;
        #1;
        chk({rs, " stall"}, 32'(disp_stall), 32'(s.xs));
        if (s.dv && s.dl && !s.xs) chk({rs, " color"}, 32'(disp_color), 32'(s.xc));
        @(posedge clk);
        #1;
        disp_valid = 1'b0; miss_valid = 1'b0; hit_valid = 1'b0;
        chk({rs, " squash"}, 32'(squash_mask), 32'(s.xsq));
        chk("R6 hold", 32'(hold_mask), 32'(s.xh));
    endtask

    function automatic stim_t mk(input logic dv, input logic [3:0] de, input logic dl,
                                 input logic p0v, input logic [3:0] p0,
                                 input logic mv, input logic [2:0] mc,
                                 input logic hv, input logic [2:0] hc,
                                 input logic xs, input logic [2:0] xc,
                                 input logic [15:0] xsq, input logic [15:0] xh,
                                 input logic [3:0] rq);
        return '{dv, de, dl, p0v, p0, 1'b0, 4'd0, mv, mc, hv, hc, xs, xc, xsq, xh, rq};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] h;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 hold", 32'(hold_mask), 32'h0);
        chk("R1 squash", 32'(squash_mask), 32'h0);
        chk("R1 stall", 32'(disp_stall), 32'h0);
        chk("R1 color", 32'(disp_color), 32'h0);

        for (int i = 0; i < NSTEP; i++) step(TBL[i]);

        // R8: fill all colors with loads on entries 8..15
        h = 16'h0000;
        for (int i = 0; i < 8; i++) begin
            h = h | (16'h0100 << i);
            step(mk(1, 4'(8 + i), 1, 0, 0, 0, 0, 0, 0, 0, 3'(i), 16'h0, h, 3));
        end
        step(mk(1, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 16'h0, h, 8));   // R8 load stalls, e0 untouched
        h = h | 16'h0002;
        step(mk(1, 1, 0, 1, 8, 0, 0, 0, 0, 0, 0, 16'h0, h, 8));   // R8 non-load proceeds
        step(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 16'h0102, h, 4)); // R4 miss c0
        h = h & ~16'h0800;
        step(mk(0, 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, 16'h0, h, 7));   // R7 hit c3
        h = h | 16'h0004;
        step(mk(1, 2, 1, 0, 0, 0, 0, 0, 0, 0, 3, 16'h0, h, 3));   // R3 c3 reallocated
        h = h & ~16'h0100;
        step(mk(1, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0, h, 12));  // R12 overwrite e8

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule